// File: doc/BRIEF.md
# Indexed MPU Region Register Bank

This block stores the programming state of a memory protection unit with a configurable number of regions. Each region owns three 32-bit words: a base address, a size/enable word and an access-control word. Each kind of word is kept in its own array with one entry per region. A single region-select register chooses which entry the three region words reach. Software reaches all four registers through a coprocessor-style access port. The port carries a primary register number, a secondary register number, an opcode field, a write flag, write data and a privilege bit.

Results are registered. Read data, the denial flag and the undefined-access flag appear one cycle after the access strobe. Whenever a region word is written, the block emits a one-cycle invalidate pulse so that downstream translation or permission caches drop stale entries. All three arrays are exposed as flat vectors for the checking logic that sits next to this block. The access port is a plain single-cycle strobe with no back-pressure: every strobed access completes, and the block never stalls the requester.

Top module: `mpu_region_bank`

## Requirements
- R1: After reset every entry of the three region arrays is zero, the region index is 0, and rd_valid, inval_pulse, undef_err and deny_err are low.
- R2: Accesses are decoded from the primary, secondary and opcode fields. (6,1,0) selects the base word, (6,1,2) selects the size word, (6,1,4) selects the access word, and (6,2,0) selects the region index.
- R3: A privileged read or write of a region word uses the entry picked by the current index. A read raises rd_valid with the data one cycle after the strobe. Each privileged write shows in the exposed arrays one cycle after the strobe.
- R4: A privileged index write whose 32-bit value is greater than or equal to NREG is ignored. The index keeps its old value and no error flag is raised.
- R5: Every privileged region-word write raises inval_pulse for exactly one cycle, in the cycle after the strobe. Reads and index writes never raise it.
- R6: A decoded access with acc_priv low raises deny_err for one cycle. It changes no array entry and does not change the index. It produces no rd_valid and no inval_pulse.
- R7: An access that decodes to no register raises undef_err for one cycle and changes no state. This holds whatever the privilege level is: the undefined-access check takes precedence over the privilege check.
- R8: A privileged read of the index register returns the index, zero-extended to 32 bits.
- R9: With NREG = 0, reads of region words and of the index return 0, region writes change nothing, and inval_pulse stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_priv | input | 1 | Requester is privileged |
| acc_crn | input | 4 | Primary register number |
| acc_crm | input | 4 | Secondary register number |
| acc_op2 | input | 3 | Opcode field |
| acc_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read completed |
| inval_pulse | output | 1 | Cache invalidate request |
| undef_err | output | 1 | Access hit no register |
| deny_err | output | 1 | Unprivileged access rejected |
| base_flat | output | NSLOT*32 | All base words, region 0 in the low bits |
| size_flat | output | NSLOT*32 | All size words |
| perm_flat | output | NSLOT*32 | All access-control words |

## Verification
The hardest state to reach from the ports is an indexed access after a rejected index write. The value that a later region access uses is never visible directly. It only shows when a region word is touched and the entry picked by the stale index is read back or exposed. The stimulus therefore fills every region with distinct patterns, then attempts out-of-range and unprivileged index writes. After each attempt it reads the index and a region word, so that a wrong index moves data into a visibly wrong slot. A second instance built with NREG = 0 receives the same stimulus and must stay silent throughout.

// File: rtl/mpu_bank_pkg.sv
package mpu_bank_pkg;
  typedef enum logic [2:0] {
    SEL_NONE, SEL_BASE, SEL_SIZE, SEL_PERM, SEL_INDEX
  } reg_sel_e;

  localparam logic [3:0] CRN_MPU    = 4'd6;
  localparam logic [3:0] CRM_REGION = 4'd1;
  localparam logic [3:0] CRM_INDEX  = 4'd2;
  localparam logic [2:0] OP_BASE    = 3'd0;
  localparam logic [2:0] OP_SIZE    = 3'd2;
  localparam logic [2:0] OP_PERM    = 3'd4;
  localparam logic [2:0] OP_INDEX   = 3'd0;
endpackage

// File: rtl/mpu_reg_decode.sv
module mpu_reg_decode
  import mpu_bank_pkg::*;
(
  input  logic [3:0] crn,
  input  logic [3:0] crm,
  input  logic [2:0] op2,
  output reg_sel_e   sel
);
  always_comb begin
    sel = SEL_NONE;
    if (crn == CRN_MPU) begin
      if (crm == CRM_REGION) begin
        case (op2)
          OP_BASE: sel = SEL_BASE;
          OP_SIZE: sel = SEL_SIZE;
          OP_PERM: sel = SEL_PERM;
          default: sel = SEL_NONE;
        endcase
      end else if (crm == CRM_INDEX && op2 == OP_INDEX) begin
        sel = SEL_INDEX;
      end
    end
  end
endmodule

// File: rtl/mpu_region_array.sv
module mpu_region_array #(
  parameter int NREG  = 8,
  parameter int NSLOT = 8,
  parameter int IW    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IW-1:0]     idx,
  input  logic [31:0]       wdata,
  output logic [NSLOT*32-1:0] flat,
  output logic [31:0]       rd_word
);
  logic [31:0] entry [NSLOT];

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    if (g < NREG) begin : g_live
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          entry[g] <= '0;
        else if (wr_en && idx == IW'(g))     entry[g] <= wdata;
      end
    end else begin : g_dead
      assign entry[g] = '0;
    end
    assign flat[g*32 +: 32] = entry[g];
  end

  always_comb begin
    rd_word = '0;
    for (int g = 0; g < NSLOT; g++)
      if (g < NREG && idx == IW'(g)) rd_word = entry[g];
  end
endmodule

// File: rtl/mpu_region_bank.sv
module mpu_region_bank
  import mpu_bank_pkg::*;
#(
  parameter int NREG = 8,
  localparam int NSLOT = (NREG == 0) ? 1 : NREG,
  localparam int IW    = (NREG <= 2) ? 1 : $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_valid,
  input  logic               acc_write,
  input  logic               acc_priv,
  input  logic [3:0]         acc_crn,
  input  logic [3:0]         acc_crm,
  input  logic [2:0]         acc_op2,
  input  logic [31:0]        acc_wdata,
  output logic [31:0]        rd_data,
  output logic               rd_valid,
  output logic               inval_pulse,
  output logic               undef_err,
  output logic               deny_err,
  output logic [NSLOT*32-1:0] base_flat,
  output logic [NSLOT*32-1:0] size_flat,
  output logic [NSLOT*32-1:0] perm_flat
);
  localparam bit HAS_REGIONS = (NREG > 0);

  reg_sel_e      sel;
  logic [IW-1:0] idx_q;
  logic          granted, wr_ok, region_wr;
  logic [2:0]    arr_we;
  logic [31:0]   arr_rd [3];
  logic [31:0]   rd_mux;

  mpu_reg_decode u_dec (
    .crn(acc_crn), .crm(acc_crm), .op2(acc_op2), .sel(sel)
  );

  assign granted   = acc_valid && acc_priv && (sel != SEL_NONE);
  assign wr_ok     = granted && acc_write;
  assign region_wr = wr_ok && HAS_REGIONS && (sel != SEL_INDEX);

  assign arr_we[0] = region_wr && (sel == SEL_BASE);
  assign arr_we[1] = region_wr && (sel == SEL_SIZE);
  assign arr_we[2] = region_wr && (sel == SEL_PERM);

  logic [NSLOT*32-1:0] flats [3];

  for (genvar a = 0; a < 3; a++) begin : g_arr
    mpu_region_array #(.NREG(NREG), .NSLOT(NSLOT), .IW(IW)) u_arr (
      .clk(clk), .rst_n(rst_n), .wr_en(arr_we[a]), .idx(idx_q),
      .wdata(acc_wdata), .flat(flats[a]), .rd_word(arr_rd[a])
    );
  end

  assign base_flat = flats[0];
  assign size_flat = flats[1];
  assign perm_flat = flats[2];

  always_comb begin
    case (sel)
      SEL_BASE:  rd_mux = arr_rd[0];
      SEL_SIZE:  rd_mux = arr_rd[1];
      SEL_PERM:  rd_mux = arr_rd[2];
      SEL_INDEX: rd_mux = HAS_REGIONS ? 32'(idx_q) : 32'd0;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q       <= '0;
      rd_data     <= '0;
      rd_valid    <= 1'b0;
      inval_pulse <= 1'b0;
      undef_err   <= 1'b0;
      deny_err    <= 1'b0;
    end else begin
      rd_valid    <= granted && !acc_write;
      inval_pulse <= region_wr;
      undef_err   <= acc_valid && (sel == SEL_NONE);
      deny_err    <= acc_valid && !acc_priv && (sel != SEL_NONE);
      if (granted && !acc_write) rd_data <= rd_mux;
      if (wr_ok && sel == SEL_INDEX && HAS_REGIONS &&
          acc_wdata < 32'(NREG))
        idx_q <= acc_wdata[IW-1:0];
    end
  end
endmodule

// File: rtl/mpu_region_bank_chk.sv
module mpu_region_bank_chk #(
  parameter int NREG = 8,
  parameter int NSLOT = 8,
  parameter int IW = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               acc_valid,
  input logic               acc_write,
  input logic               acc_priv,
  input logic [3:0]         acc_crn,
  input logic [3:0]         acc_crm,
  input logic [2:0]         acc_op2,
  input logic               rd_valid,
  input logic               inval_pulse,
  input logic               undef_err,
  input logic               deny_err,
  input logic [NSLOT*32-1:0] base_flat,
  input logic [NSLOT*32-1:0] size_flat,
  input logic [NSLOT*32-1:0] perm_flat,
  input logic [IW-1:0]      idx_q
);
  logic hit_region, hit_index, hit_any;
  assign hit_region = acc_crn == 4'd6 && acc_crm == 4'd1 &&
                      (acc_op2 == 3'd0 || acc_op2 == 3'd2 || acc_op2 == 3'd4);
  assign hit_index  = acc_crn == 4'd6 && acc_crm == 4'd2 && acc_op2 == 3'd0;
  assign hit_any    = hit_region || hit_index;

  p_idx_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (NREG == 0) || (int'(idx_q) < NREG));

  p_flags_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({undef_err, deny_err, rd_valid, inval_pulse}));

  p_inval_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_write && acc_priv && hit_region && (NREG > 0)
    |=> inval_pulse);

  p_no_spur_inval_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && acc_write && acc_priv && hit_region) |=> !inval_pulse);

  p_deny_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !acc_priv && hit_any |=> deny_err &&
    $stable(base_flat) && $stable(size_flat) && $stable(perm_flat) &&
    $stable(idx_q));

  p_undef_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !hit_any |=> undef_err &&
    $stable(base_flat) && $stable(size_flat) && $stable(perm_flat) &&
    $stable(idx_q));

  p_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !acc_write && acc_priv && hit_any |=> rd_valid);
endmodule

bind mpu_region_bank mpu_region_bank_chk #(.NREG(NREG), .NSLOT(NSLOT), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_priv(acc_priv), .acc_crn(acc_crn), .acc_crm(acc_crm),
  .acc_op2(acc_op2), .rd_valid(rd_valid), .inval_pulse(inval_pulse),
  .undef_err(undef_err), .deny_err(deny_err), .base_flat(base_flat),
  .size_flat(size_flat), .perm_flat(perm_flat), .idx_q(idx_q)
);

// File: tb/sim_mpu_region_bank.sv
`timescale 1ns/1ps
module sim_mpu_region_bank;
  localparam int N = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic acc_valid = 0, acc_write = 0, acc_priv = 0;
  logic [3:0] acc_crn = 0, acc_crm = 0;
  logic [2:0] acc_op2 = 0;
  logic [31:0] acc_wdata = 0;

  logic [31:0] rd_data, z_rd_data;
  logic rd_valid, inval_pulse, undef_err, deny_err;
  logic z_rd_valid, z_inval, z_undef, z_deny;
  logic [N*32-1:0] base_flat, size_flat, perm_flat;
  logic [31:0] z_base, z_size, z_perm;

  always #2.5 clk = ~clk;

  mpu_region_bank #(.NREG(N)) u0 (
    .clk, .rst_n, .acc_valid, .acc_write, .acc_priv, .acc_crn, .acc_crm,
    .acc_op2, .acc_wdata, .rd_data, .rd_valid, .inval_pulse, .undef_err,
    .deny_err, .base_flat, .size_flat, .perm_flat
  );

  mpu_region_bank #(.NREG(0)) u_zero (
    .clk, .rst_n, .acc_valid, .acc_write, .acc_priv, .acc_crn, .acc_crm,
    .acc_op2, .acc_wdata, .rd_data(z_rd_data), .rd_valid(z_rd_valid),
    .inval_pulse(z_inval), .undef_err(z_undef), .deny_err(z_deny),
    .base_flat(z_base), .size_flat(z_size), .perm_flat(z_perm)
  );

  int n_vec = 0, n_bad = 0;
  string tag = "R1";

  // reference model
  int unsigned mregs [3][N];
  int unsigned midx = 0;
  logic [31:0] e_rd = 0;
  bit e_rv = 0, e_inv = 0, e_und = 0, e_den = 0;

  task automatic chk(string t, string what, longint act, longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(tag, "rd_valid", rd_valid, e_rv);
    chk(tag, "inval_pulse (R5)", inval_pulse, e_inv);
    chk(tag, "undef_err (R7)", undef_err, e_und);
    chk(tag, "deny_err (R6)", deny_err, e_den);
    if (e_rv) chk(tag, "rd_data (R3)", rd_data, e_rd);
    for (int g = 0; g < N; g++) begin
      chk(tag, "base array (R3)", base_flat[g*32 +: 32], mregs[0][g]);
      chk(tag, "size array (R3)", size_flat[g*32 +: 32], mregs[1][g]);
      chk(tag, "perm array (R3)", perm_flat[g*32 +: 32], mregs[2][g]);
    end
    // R9: zero-region instance stays silent
    chk("R9", "zero inst inval", z_inval, 0);
    chk("R9", "zero inst arrays", {z_base, z_size, z_perm}, 0);
    if (z_rd_valid) chk("R9", "zero inst rd_data", z_rd_data, 0);
  endtask

  // one cycle: compare at negedge, then drive and advance the model
  task automatic cyc(bit v, bit w, bit p, int crn, int crm, int op2,
                     logic [31:0] d);
    int kind;
    @(negedge clk);
    compare();
    acc_valid = v; acc_write = w; acc_priv = p;
    acc_crn = 4'(crn); acc_crm = 4'(crm); acc_op2 = 3'(op2); acc_wdata = d;
    e_rv = 0; e_inv = 0; e_und = 0; e_den = 0;
    if (!v) return;
    kind = -1;
    if (crn == 6 && crm == 1 && op2 == 0) kind = 0;
    if (crn == 6 && crm == 1 && op2 == 2) kind = 1;
    if (crn == 6 && crm == 1 && op2 == 4) kind = 2;
    if (crn == 6 && crm == 2 && op2 == 0) kind = 3;
    if (kind < 0) e_und = 1;
    else if (!p) e_den = 1;
    else if (w) begin
      if (kind == 3) begin
        if (d < N) midx = d;
      end else begin
        mregs[kind][midx] = d;
        e_inv = 1;
      end
    end else begin
      e_rv = 1;
      e_rd = (kind == 3) ? midx : mregs[kind][midx];
    end
  endtask

  task automatic idle(); cyc(0, 0, 0, 0, 0, 0, 0); endtask
  task automatic wr(int op2, logic [31:0] d); cyc(1, 1, 1, 6, 1, op2, d); endtask
  task automatic rd(int op2); cyc(1, 0, 1, 6, 1, op2, 0); endtask
  task automatic set_idx(logic [31:0] d); cyc(1, 1, 1, 6, 2, 0, d); endtask
  task automatic get_idx(); cyc(1, 0, 1, 6, 2, 0, 0); endtask

  initial begin
    #(5.0 * 200000);
    n_vec++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int a = 0; a < 3; a++) for (int g = 0; g < N; g++) mregs[a][g] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tag = "R1"; idle(); idle(); get_idx(); rd(0); rd(2); rd(4);
    // R2, R3: fill every region through the index, distinct words
    tag = "R2";
    for (int g = 0; g < N; g++) begin
      set_idx(g);
      wr(0, 32'h1000_0000 + g * 32'h100);
      wr(2, 32'h2000_0000 + g);
      wr(4, 32'h3000_0000 ^ (g << 8));
    end
    tag = "R3";
    for (int g = N - 1; g >= 0; g--) begin
      set_idx(g); rd(0); rd(2); rd(4); idle();
    end
    // back-to-back write then read of same word
    wr(2, 32'hDEAD_BEEF); rd(2); wr(2, 32'h0000_0001); rd(2);
    tag = "R8"; set_idx(5); get_idx(); set_idx(N - 1); get_idx();
    // R4: out-of-range index writes ignored
    tag = "R4";
    set_idx(3); set_idx(N); get_idx(); wr(0, 32'hAAAA_0003); rd(0);
    set_idx(100); set_idx(32'hFFFF_FFFF); get_idx(); rd(4);
    set_idx(0); set_idx(32'h8000_0000); wr(4, 32'h5555_0000); get_idx();
    // R6: unprivileged accesses rejected
    tag = "R6";
    cyc(1, 1, 0, 6, 1, 0, 32'h1234_5678); rd(0);
    cyc(1, 1, 0, 6, 2, 0, 2); get_idx();
    cyc(1, 0, 0, 6, 1, 4, 0); idle();
    // R7: unmapped encodings, any privilege
    tag = "R7";
    cyc(1, 1, 1, 5, 1, 0, 32'hFFFF); cyc(1, 1, 1, 6, 1, 1, 7);
    cyc(1, 1, 1, 6, 2, 1, 1); cyc(1, 0, 1, 6, 3, 0, 0);
    cyc(1, 1, 0, 7, 1, 0, 9); cyc(1, 1, 1, 6, 0, 0, 4); get_idx(); rd(0);
    // R5: write bursts, pulse per write
    tag = "R5";
    wr(0, 1); wr(2, 2); wr(4, 3); idle(); rd(0); set_idx(2); idle();
    tag = "R9";
    wr(0, 32'hCAFE); rd(0); get_idx(); idle();
    @(negedge clk); compare();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule